// File: doc/BRIEF.md
# Flash Busy-Status Read Responder

This block sits between the read data path of a flash device model and a small synchronous byte array. It receives byte-program and chip-erase requests from a command interpreter, times each operation with parameterised cycle counts, and performs the array updates itself. A program merges the new byte into the stored byte so that bits can only be cleared. An erase first waits out its timer and then sweeps the array one location per clock, writing all-ones. Locations inside a boot region are skipped when the region's lock input is set.

While an operation is in progress, a read does not return array data. It returns a status byte instead. Bit 7 of that byte is the complement of bit 7 of the value being written: the program data for a program, all-ones for an erase. Bit 6 flips on every status read. Once the block is idle again, reads return the true stored byte. Software can therefore poll either bit to learn when the operation has finished.

Top module: `flash_busy_status`

## Requirements
- R1: After reset `busy` and `mem_we` are low, and a read returns the stored array byte.
- R2: An accepted program keeps `busy` high for exactly PROG_CYCLES+1 clocks, counted from the clock edge that accepts it. It issues a single array write, in its last busy cycle.
- R3: A read strobed while busy returns a status byte. Bit 7 is the complement of bit 7 of the value being written, and bits 5..0 are zero.
- R4: Bit 6 of the status byte is 0 on the first status read after reset and flips on every later status read. The flip carries over from one operation to the next, and reads made while idle leave it unchanged.
- R5: A read strobed while idle shows the array byte at `rd_addr` on `rd_data` in the clock cycle after the strobe. Status bytes use the same one-cycle latency.
- R6: A program stores the bitwise AND of the old byte and the new data byte.
- R7: An accepted erase keeps `busy` high for ERASE_CYCLES + 2^ADDR_W clocks and leaves every unprotected byte at 8'hFF. Its status reads show bit 7 = 0.
- R8: The boot region is the lowest BOOT_WORDS addresses when BOOT_TOP=0 and the highest BOOT_WORDS addresses otherwise. With `boot_lock` high, an erase leaves that region untouched, and a program aimed into it is dropped without raising `busy`.
- R9: Program and erase requests that arrive while busy are ignored. They neither lengthen the operation nor change the array.
- R10: If a program request and an erase request arrive in the same idle cycle, the erase is taken and the program is dropped.
- R11: The byte returned by a status read does not depend on `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_req | input | 1 | Byte program request pulse |
| prog_addr | input | ADDR_W | Program target address |
| prog_data | input | 8 | Program data byte |
| erase_req | input | 1 | Chip erase request pulse |
| boot_lock | input | 1 | Boot region write protection enable |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result, valid the cycle after the strobe |
| busy | output | 1 | Operation in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array address for reads and writes |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, one cycle after `mem_addr` |

## Verification
Some properties are checked on every cycle by the assertions. Status bytes always have their low six bits clear, and the toggle bit alternates between consecutive status reads. No array write turns a 0 bit into a 1, except the all-ones erase pattern. No write happens while idle, and no write lands in the boot region while it is locked. Other behaviour only shows up in the bench scenarios, which track a shadow copy of the array. These cover:
- the exact busy lengths of program and erase;
- the value of the data-polling bit for many different data bytes;
- requests that arrive mid-operation and are dropped;
- erase winning over a simultaneous program;
- the final array contents, both with and without the boot lock.

// File: rtl/flash_bsr_pkg.sv
package flash_bsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWAIT,
    ST_PWRITE,
    ST_EWAIT,
    ST_ESWEEP
  } seq_state_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  // Status byte: polling bit on 7, toggle on 6, remaining bits clear.
  function automatic logic [7:0] status_byte(input logic poll, input logic tog);
    return {poll, tog, 6'b000000};
  endfunction

endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_bsr_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int PROG_CYCLES  = 12,
  parameter int ERASE_CYCLES = 30,
  parameter int BOOT_WORDS   = 8,
  parameter int BOOT_TOP     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic              erase_req,
  input  logic              boot_lock,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              tgt_bit7,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int TMAX  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int AW1   = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [7:0]        pd_q, pd_d;
  logic [ADDR_W-1:0] sweep_q, sweep_d;
  logic              t_load;
  logic [TW-1:0]     t_val;
  logic              t_expired;
  logic              pa_boot;
  logic              sw_boot;

  // Boot region decode: the parameter picks bottom or top placement.
  generate
    if (BOOT_TOP != 0) begin : g_boot_top
      assign pa_boot = ({1'b0, prog_addr} >= AW1'(DEPTH - BOOT_WORDS));
      assign sw_boot = ({1'b0, sweep_q}   >= AW1'(DEPTH - BOOT_WORDS));
    end else begin : g_boot_bottom
      assign pa_boot = ({1'b0, prog_addr} < AW1'(BOOT_WORDS));
      assign sw_boot = ({1'b0, sweep_q}   < AW1'(BOOT_WORDS));
    end
  endgenerate

  flash_op_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  always_comb begin
    state_d = state_q;
    pa_d    = pa_q;
    pd_d    = pd_q;
    sweep_d = sweep_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (erase_req) begin
          state_d = ST_EWAIT;
          sweep_d = '0;
          t_load  = 1'b1;
          t_val   = TW'(ERASE_CYCLES - 1);
        end else if (prog_req && !(boot_lock && pa_boot)) begin
          state_d = ST_PWAIT;
          pa_d    = prog_addr;
          pd_d    = prog_data;
          t_load  = 1'b1;
          t_val   = TW'(PROG_CYCLES - 1);
        end
      end
      ST_PWAIT: begin
        if (t_expired) begin
          state_d = ST_PWRITE;
        end
      end
      ST_PWRITE: begin
        state_d = ST_IDLE;
      end
      ST_EWAIT: begin
        if (t_expired) begin
          state_d = ST_ESWEEP;
        end
      end
      ST_ESWEEP: begin
        sweep_d = sweep_q + 1'b1;
        if (sweep_q == LAST_ADDR) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pa_q    <= '0;
      pd_q    <= '0;
      sweep_q <= '0;
    end else begin
      state_q <= state_d;
      pa_q    <= pa_d;
      pd_q    <= pd_d;
      sweep_q <= sweep_d;
    end
  end

  always_comb begin
    busy      = (state_q != ST_IDLE);
    tgt_bit7  = pd_q[7];
    mem_we    = 1'b0;
    mem_addr  = rd_addr;
    mem_wdata = ERASED_BYTE;
    unique case (state_q)
      ST_PWAIT: begin
        mem_addr = pa_q;
      end
      ST_PWRITE: begin
        mem_addr  = pa_q;
        mem_we    = 1'b1;
        mem_wdata = mem_rdata & pd_q;
      end
      ST_EWAIT: begin
        tgt_bit7 = 1'b1;
      end
      ST_ESWEEP: begin
        tgt_bit7 = 1'b1;
        mem_addr = sweep_q;
        mem_we   = !(boot_lock && sw_boot);
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/flash_stat_resp.sv
module flash_stat_resp
  import flash_bsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_stb,
  input  logic       busy,
  input  logic       tgt_bit7,
  input  logic [7:0] mem_rdata,
  output logic [7:0] rd_data
);

  logic       tog_q, tog_d;
  logic       sel_q, sel_d;
  logic [7:0] stat_q, stat_d;
  logic       stat_rd;

  always_comb begin
    stat_rd = rd_stb & busy;
    tog_d   = tog_q ^ stat_rd;
    sel_d   = rd_stb ? busy : sel_q;
    stat_d  = stat_rd ? status_byte(~tgt_bit7, tog_q) : stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q  <= 1'b0;
      sel_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      tog_q  <= tog_d;
      sel_q  <= sel_d;
      stat_q <= stat_d;
    end
  end

  assign rd_data = sel_q ? stat_q : mem_rdata;

endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status #(
  parameter int ADDR_W       = 6,
  parameter int PROG_CYCLES  = 12,
  parameter int ERASE_CYCLES = 30,
  parameter int BOOT_WORDS   = 8,
  parameter int BOOT_TOP     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic              erase_req,
  input  logic              boot_lock,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  logic rst_n_s;
  logic tgt_bit7;

  flash_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  flash_op_seq #(
    .ADDR_W       (ADDR_W),
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES),
    .BOOT_WORDS   (BOOT_WORDS),
    .BOOT_TOP     (BOOT_TOP)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .prog_req  (prog_req),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .erase_req (erase_req),
    .boot_lock (boot_lock),
    .rd_addr   (rd_addr),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .tgt_bit7  (tgt_bit7),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  flash_stat_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rd_stb    (rd_stb),
    .busy      (busy),
    .tgt_bit7  (tgt_bit7),
    .mem_rdata (mem_rdata),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/flash_busy_status_chk.sv
module flash_busy_status_chk #(
  parameter int ADDR_W     = 6,
  parameter int BOOT_WORDS = 8,
  parameter int BOOT_TOP   = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic              busy,
  input logic [7:0]        rd_data,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic [7:0]        mem_rdata,
  input logic              boot_lock
);

  localparam int DEPTH = 1 << ADDR_W;

  logic pend_q;
  logic seen_q;
  logic last_q;
  logic in_boot;

  assign in_boot = (BOOT_TOP != 0) ? (int'(mem_addr) >= DEPTH - BOOT_WORDS)
                                   : (int'(mem_addr) < BOOT_WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      seen_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      pend_q <= rd_stb & busy;
      if (pend_q) begin
        seen_q <= 1'b1;
        last_q <= rd_data[6];
      end
    end
  end

  // R3: status bytes carry nothing in bits 5..0
  p_status_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy) |=> (rd_data[5:0] == 6'd0));

  // R4: first status read shows toggle 0
  p_toggle_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !seen_q) |-> (rd_data[6] == 1'b0));

  // R4: consecutive status reads alternate bit 6
  p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && seen_q) |-> (rd_data[6] != last_q));

  // R6: a non-erase write never raises a bit
  p_clear_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (mem_wdata != 8'hFF)) |-> ((mem_wdata & ~mem_rdata) == 8'h00));

  // R8: no write into the locked boot region
  p_boot_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && boot_lock) |-> !in_boot);

  // R2: the array is only written during an operation
  p_no_idle_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);

endmodule

bind flash_busy_status flash_busy_status_chk #(
  .ADDR_W     (ADDR_W),
  .BOOT_WORDS (BOOT_WORDS),
  .BOOT_TOP   (BOOT_TOP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_stb    (rd_stb),
  .busy      (busy),
  .rd_data   (rd_data),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .boot_lock (boot_lock)
);

// File: tb/test_flash_busy_status.sv
`timescale 1ns/1ps
module test_flash_busy_status;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int P     = 12;
  localparam int E     = 30;
  localparam int BW    = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          prog_req;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data;
  logic          erase_req;
  logic          boot_lock;
  logic          rd_stb;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          busy;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata;

  logic [7:0] mem    [DEPTH];
  logic [7:0] shadow [DEPTH];
  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  logic exp_tog = 1'b0;

  always #2.5 clk = ~clk;

  flash_busy_status #(
    .ADDR_W(AW), .PROG_CYCLES(P), .ERASE_CYCLES(E), .BOOT_WORDS(BW), .BOOT_TOP(0)
  ) i_flash_busy_status (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_req(erase_req), .boot_lock(boot_lock),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Array model: synchronous, read returns the old byte
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_stb = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_stb = 1'b0;
    d = rd_data;
  endtask

  task automatic stat_rd(input logic [AW-1:0] a, input logic exp7, input string req);
    logic [7:0] v;
    rd(a, v);
    chk({req, " R3 poll bit"}, v[7], exp7);
    chk("R4 toggle bit", v[6], exp_tog);
    chk("R3 R11 low bits", v[5:0], 6'd0);
    exp_tog = ~exp_tog;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic pulse(input logic p, input logic e, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    prog_req = p; erase_req = e; prog_addr = a; prog_data = d;
    @(negedge clk);
    prog_req = 1'b0; erase_req = 1'b0;
  endtask

  function automatic bit is_boot(input int a);
    return a < BW;
  endfunction

  task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d, input int nreads);
    int c0;
    logic [7:0] v;
    pulse(1'b1, 1'b0, a, d);
    c0 = cyc;
    chk("R2 busy after accept", busy, 1'b1);
    for (int k = 0; k < nreads; k++) stat_rd(AW'(a + k * 13 + 5), ~d[7], "R11");
    wait_idle();
    chk("R2 program busy length", cyc - c0, P + 1);
    shadow[a] = shadow[a] & d;
    rd(a, v);
    chk("R6 AND merge", v, shadow[a]);
  endtask

  task automatic do_erase(input logic with_prog, input logic [AW-1:0] pa);
    int c0;
    logic [7:0] v;
    pulse(with_prog, 1'b1, pa, 8'h00);
    c0 = cyc;
    stat_rd(AW'(c0), 1'b0, "R7");
    stat_rd(AW'(c0 + 7), 1'b0, "R7");
    wait_idle();
    chk("R7 erase busy length", cyc - c0, E + DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      if (!(boot_lock && is_boot(i))) shadow[i] = 8'hFF;
      rd(AW'(i), v);
      chk("R7 R8 R10 erased contents", v, shadow[i]);
    end
  endtask

  initial begin
    logic [7:0] v;
    int c0;
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'(i * 37 + 5);
      shadow[i] = 8'(i * 37 + 5);
    end
    rst_n = 1'b0; prog_req = 1'b0; erase_req = 1'b0; boot_lock = 1'b0;
    rd_stb = 1'b0; rd_addr = '0; prog_addr = '0; prog_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 busy after reset", busy, 1'b0);
    chk("R1 mem_we after reset", mem_we, 1'b0);

    // R5: exhaustive idle reads
    for (int i = 0; i < DEPTH; i++) begin
      rd(AW'(i), v);
      chk("R5 R1 idle read", v, shadow[i]);
    end

    // R2 R3 R4 R6: program every unprotected address; idle reads in between keep toggle (R4)
    for (int a = BW; a < DEPTH; a++) do_prog(AW'(a), 8'(a * 91 + 3), a % 4);

    // R9: requests arriving mid-operation are dropped
    pulse(1'b1, 1'b0, AW'(20), 8'h0F);
    c0 = cyc;
    pulse(1'b1, 1'b0, AW'(21), 8'h00);
    pulse(1'b0, 1'b1, AW'(21), 8'h00);
    wait_idle();
    chk("R9 busy not extended", cyc - c0, P + 1);
    shadow[20] = shadow[20] & 8'h0F;
    rd(AW'(20), v); chk("R9 first op done", v, shadow[20]);
    rd(AW'(21), v); chk("R9 dropped program", v, shadow[21]);
    rd(AW'(40), v); chk("R9 dropped erase", v, shadow[40]);

    // R7: unlocked erase
    do_erase(1'b0, '0);

    // R8: program boot while unlocked, then lock
    do_prog(AW'(2), 8'h5A, 1);
    boot_lock = 1'b1;
    pulse(1'b1, 1'b0, AW'(3), 8'h00);
    chk("R8 locked program not accepted", busy, 1'b0);
    repeat (P + 3) @(negedge clk);
    rd(AW'(3), v); chk("R8 locked byte unchanged", v, shadow[3]);
    do_prog(AW'(40), 8'h33, 2);
    do_erase(1'b0, '0);
    boot_lock = 1'b0;

    // R10: simultaneous program and erase, erase wins
    do_erase(1'b1, AW'(50));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule